// File: doc/BRIEF.md
# Test-Mode Reference Divider

This block produces the production-test clock set from a single reference clock. The reference is forwarded unchanged. A half-rate output and a quarter-rate output are derived from it, along with a bank of identical bus clocks. The bus clocks run at either a quarter or a third of the reference rate. The choice is made by a strap that is captured while reset is held.

The third-rate bus clock has a balanced duty cycle. It is high for one and a half reference periods, and the falling-edge half of the logic sets where that high time ends. When the test-enable input is low, all the divided clocks are held low and every counter is cleared. Because the counters restart together, all divided outputs rise on the same reference rising edge once the enable returns.

In the requirements, k counts the enabled rising edges since the last reset or the last edge with the enable low. k starts at 1 on the first enabled edge.

Top module: `test_ref_divider`

## Requirements
- R1: `refOut` equals `refClk` at all times, in every mode and during reset.
- R2: After the k-th enabled rising edge, `clkHalf` is high when k is odd and low when k is even.
- R3: After the k-th enabled rising edge, `clkQuarter` is high when k mod 4 is 1 or 2, and low otherwise. This gives a 4-period cycle with 50% duty.
- R4: When the captured strap is 1, every `busOut` bit follows the `clkQuarter` pattern of R3.
- R5: When the captured strap is 0, every `busOut` bit repeats every 3 periods. It goes high on the edge where k mod 3 is 1 and goes low on the falling edge after the edge where k mod 3 is 2, so it is high for 1.5 periods.
- R6: On a rising edge that samples `testEn` low, all divided outputs go low and stay low while the enable stays low. The next enabled edge counts as k = 1.
- R7: While `rstN` is low, all divided outputs are low. The strap is loaded from `busSel` on each rising edge during reset. After reset is released, changes on `busSel` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset; the strap loads while this is low |
| testEn | input | 1 | Enables the dividers; when low, the divided outputs are held low |
| busSel | input | 1 | Bus-rate strap: 1 selects divide by 4, 0 selects divide by 3 |
| refOut | output | 1 | Forwarded reference |
| clkHalf | output | 1 | Reference divided by 2 |
| clkQuarter | output | 1 | Reference divided by 4 |
| busOut | output | BUS_COUNT | Bus clocks, divide by 4 or by 3 |

## Verification
The half-rate and quarter-rate outputs, and the bus clock in its quarter mode, change only at the rising edge that counts the edge, with no further register stage. They are therefore checked 1 ns after each rising edge and again 1 ns after the following falling edge. The third-rate bus clock is the only output that can change on a falling edge. It is compared in both half-periods against a model indexed by k mod 3. The model's count is updated at each rising edge from the inputs held stable across it, and inputs change only after the falling-edge check. This keeps every compare one settled half-period after the edge that caused it.

// File: rtl/test_ref_divider_pkg.sv
package test_ref_divider_pkg;
  localparam int THIRD_DIV = 3;
  localparam int THIRD_W   = $clog2(THIRD_DIV);
  localparam int GRAY_W    = 2;

  typedef struct packed {
    logic              advance;
    logic              useDiv3;
    logic [GRAY_W-1:0] grayNext;
    logic              thirdNext;
  } divStrobe_t;
endpackage

// File: rtl/test_ref_divider_ctrl.sv
module test_ref_divider_ctrl
  import test_ref_divider_pkg::*;
(
  input  logic       refClk,
  input  logic       rstN,
  input  logic       testEn,
  input  logic       busSel,
  output divStrobe_t strb
);
  localparam logic [THIRD_W-1:0] THIRD_LAST = THIRD_W'(THIRD_DIV - 1);
  localparam logic [THIRD_W-1:0] THIRD_ONE  = THIRD_W'(1);

  logic [GRAY_W-1:0]  grayQ, grayNxt;
  logic [THIRD_W-1:0] modQ, modNxt;
  logic               strapQ;

  // strap follows the pin only while reset is held
  always_ff @(posedge refClk) begin
    if (!rstN) strapQ <= busSel;
  end

  always_comb begin
    if (testEn) begin
      grayNxt = {grayQ[0], ~grayQ[GRAY_W-1]};
      modNxt  = (modQ == THIRD_LAST) ? '0 : modQ + THIRD_ONE;
    end else begin
      grayNxt = '0;
      modNxt  = '0;
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      grayQ <= '0;
      modQ  <= '0;
    end else begin
      grayQ <= grayNxt;
      modQ  <= modNxt;
    end
  end

  always_comb begin
    strb.advance   = testEn;
    strb.useDiv3   = ~strapQ;
    strb.grayNext  = grayNxt;
    strb.thirdNext = (modNxt == THIRD_ONE);
  end
endmodule

// File: rtl/test_ref_divider_datapath.sv
module test_ref_divider_datapath
  import test_ref_divider_pkg::*;
#(
  parameter int BUS_COUNT = 6
) (
  input  logic                 refClk,
  input  logic                 rstN,
  input  divStrobe_t           strb,
  output logic                 clkHalf,
  output logic                 clkQuarter,
  output logic [BUS_COUNT-1:0] busOut
);
  logic halfQ, quarterQ, posThird, negThird, runQ, busSig;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      halfQ    <= 1'b0;
      quarterQ <= 1'b0;
      posThird <= 1'b0;
      runQ     <= 1'b0;
    end else begin
      halfQ    <= ^strb.grayNext;
      quarterQ <= strb.grayNext[0];
      posThird <= strb.thirdNext;
      runQ     <= strb.advance;
    end
  end

  // falling-edge copy stretches the third-rate pulse by half a period
  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) negThird <= 1'b0;
    else       negThird <= posThird;
  end

  always_comb begin
    if (strb.useDiv3) busSig = posThird | (negThird & runQ);
    else              busSig = quarterQ;
  end

  assign clkHalf    = halfQ;
  assign clkQuarter = quarterQ;

  for (genvar i = 0; i < BUS_COUNT; i++) begin : g_bus
    assign busOut[i] = busSig;
  end
endmodule

// File: rtl/test_ref_divider.sv
module test_ref_divider
  import test_ref_divider_pkg::*;
#(
  parameter int BUS_COUNT = 6
) (
  input  logic                 refClk,
  input  logic                 rstN,
  input  logic                 testEn,
  input  logic                 busSel,
  output logic                 refOut,
  output logic                 clkHalf,
  output logic                 clkQuarter,
  output logic [BUS_COUNT-1:0] busOut
);
  divStrobe_t strb;

  test_ref_divider_ctrl ctrl_i (
    .refClk (refClk),
    .rstN   (rstN),
    .testEn (testEn),
    .busSel (busSel),
    .strb   (strb)
  );

  test_ref_divider_datapath #(.BUS_COUNT(BUS_COUNT)) dp_i (
    .refClk     (refClk),
    .rstN       (rstN),
    .strb       (strb),
    .clkHalf    (clkHalf),
    .clkQuarter (clkQuarter),
    .busOut     (busOut)
  );

  assign refOut = refClk;
endmodule

// File: rtl/test_ref_divider_chk.sv
module test_ref_divider_chk (
  input logic refClk,
  input logic rstN,
  input logic testEn,
  input logic clkHalf,
  input logic clkQuarter,
  input logic busFirst,
  input logic useDiv3
);
  p_hold_low_r6: assert property (@(posedge refClk) disable iff (!rstN)
    !testEn |=> (!clkHalf && !clkQuarter && !busFirst));

  p_half_toggle_r2: assert property (@(posedge refClk) disable iff (!rstN)
    testEn |=> (clkHalf != $past(clkHalf)));

  p_quarter_flip_r3: assert property (@(posedge refClk) disable iff (!rstN)
    (testEn && !clkHalf) |=> (clkQuarter != $past(clkQuarter)));

  p_quarter_keep_r3: assert property (@(posedge refClk) disable iff (!rstN)
    (testEn && clkHalf) |=> $stable(clkQuarter));

  p_third_gap_r5: assert property (@(posedge refClk) disable iff (!rstN)
    (useDiv3 && busFirst) |=> !busFirst);
endmodule

bind test_ref_divider test_ref_divider_chk chk_i (
  .refClk     (refClk),
  .rstN       (rstN),
  .testEn     (testEn),
  .clkHalf    (clkHalf),
  .clkQuarter (clkQuarter),
  .busFirst   (busOut[0]),
  .useDiv3    (strb.useDiv3)
);

// File: tb/test_ref_divider_tb_top.sv
`timescale 1ns/1ps
module test_ref_divider_tb_top;
  localparam int BUS_COUNT = 6;
  localparam int MAX_CYCLES = 200000;

  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic testEn = 1'b1;
  logic busSel = 1'b1;
  logic refOut, clkHalf, clkQuarter;
  logic [BUS_COUNT-1:0] busOut;

  int vectors = 0;
  int misses = 0;
  int k = 0;
  logic strapM = 1'b1;

  test_ref_divider #(.BUS_COUNT(BUS_COUNT)) dut_i (
    .refClk(refClk), .rstN(rstN), .testEn(testEn), .busSel(busSel),
    .refOut(refOut), .clkHalf(clkHalf), .clkQuarter(clkQuarter), .busOut(busOut)
  );

  always #2 refClk = ~refClk;

  task automatic check(string req, string name, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, name, $time, act, exp);
    end
  endtask

  // phaseHigh: 1 = checked just after rising edge, 0 = just after falling edge
  task automatic checkPhase(logic phaseHigh);
    logic e2, e4, eb;
    string tagD, tagB;
    e2 = (k % 2) == 1;
    e4 = ((k % 4) == 1) || ((k % 4) == 2);
    if (strapM) eb = e4;
    else if (phaseHigh) eb = ((k % 3) == 1) || ((k % 3) == 2);
    else eb = (k % 3) == 1;
    tagD = !rstN ? "R7" : (k == 0 ? "R6" : "");
    check("R1", "refOut", refOut, phaseHigh);
    check(tagD != "" ? tagD : "R2", "clkHalf", clkHalf, e2);
    check(tagD != "" ? tagD : "R3", "clkQuarter", clkQuarter, e4);
    tagB = tagD != "" ? tagD : (strapM ? "R4" : "R5");
    for (int i = 0; i < BUS_COUNT; i++)
      check(tagB, $sformatf("busOut[%0d]", i), busOut[i], eb);
  endtask

  task automatic cycles(int n);
    repeat (n) begin
      @(posedge refClk);
      if (!rstN) begin
        k = 0;
        strapM = busSel;
      end else if (!testEn) k = 0;
      else k++;
      #1 checkPhase(1'b1);
      @(negedge refClk);
      #1 checkPhase(1'b0);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(MAX_CYCLES * 4);
    misses++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    // R7: reset with strap 1, outputs low during reset
    rstN = 1'b0; testEn = 1'b1; busSel = 1'b1;
    cycles(3);
    rstN = 1'b1;
    // R2 R3 R4: quarter-rate bus
    cycles(9);
    // R7: strap change after reset is ignored
    busSel = 1'b0;
    cycles(9);
    // R6: enable low clears and holds outputs low
    testEn = 1'b0;
    cycles(3);
    testEn = 1'b1;
    cycles(10);
    // R7 R5: reset with strap 0, third-rate bus
    rstN = 1'b0;
    cycles(2);
    rstN = 1'b1;
    cycles(14);
    // R6 with third-rate bus: one-cycle disable restarts phase
    testEn = 1'b0;
    cycles(1);
    testEn = 1'b1;
    cycles(7);
    busSel = 1'b1;
    cycles(12);
    // R7: back to strap 1 via reset
    rstN = 1'b0;
    cycles(2);
    rstN = 1'b1;
    cycles(8);
    finishRun();
  end
endmodule